// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synchronous static RAM built from a register array. It holds 256 words of two 9-bit byte lanes. The host may issue a read or a write on every clock edge. No idle cycles are needed when the bus turns from reads to writes, because write data is not taken with the address. It is taken later, in the same bus slot where read data of that command would appear. Address, control and write data are all taken on the rising clock edge.

Two static inputs set how the block runs. The first chooses between pipelined timing and flow-through timing. Pipelined timing puts a register in front of the read data; flow-through timing drives read data straight from the array. The second chooses the order in which a four-beat burst steps through its addresses.

A command is accepted only when all three chip enables are in their active state. Writes can be limited to single byte lanes. A continuation input steps a burst counter that was preset from the two low address bits.

An asynchronous output enable and an asynchronous sleep input can turn the read-data outputs off at any moment. Sleep also blocks new commands. The data bus is split into a data-in port, a data-out port and a flag that says the data-out port is driven.

Top module: `zt_sram`

## Requirements
- R1: A read or write command may be issued on every clock edge. Any mix of reads and writes returns the results of a memory updated in command order, with no idle cycle between them.
- R2: With `flow_n`=1 (pipelined), read data for a command taken at edge T is driven between edges T+1 and T+2. Write data for a write taken at edge T is taken at edge T+2.
- R3: With `flow_n`=0 (flow-through), read data for a command taken at edge T is driven between edges T and T+1. Write data for a write taken at edge T is taken at edge T+1.
- R4: A new command is accepted only when `sel_a_n`=0, `sel_c_n`=0 and `sel_b`=1. In every other case the cycle is a deselect: nothing is written, and no burst continues after it.
- R5: A write is issued with `we_n`=0. It updates lane i, bits [9i+8:9i], only when `lane_we_n[i]`=0. The other lane keeps its contents.
- R6: While `oe_n`=1, `rdata_vld` is 0 and `rdata` is 0. This takes effect at once, without waiting for a clock edge.
- R7: When `burst_next`=1, chip enables and `we_n` are ignored, and the last accepted command continues with beat k+1 (modulo 4). The low two address bits are (preset+k) mod 4 when `order_il`=0, and preset XOR k when `order_il`=1.
- R8: When `sleep`=1 at an edge, that edge's command is ignored and any burst ends. While `sleep`=1, `rdata_vld` and `rdata` are 0 at once, without waiting for a clock edge.
- R9: A read of an address whose late write data has not yet been stored returns the pending lanes merged with the stored word.
- R10: In the bus slot of a write, a deselect or a sleep cycle, `rdata_vld` is 0 and `rdata` is 0.
- R11: While `rst_n`=0 and after it is released, `rdata_vld` is 0 until a read's slot arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is taken on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| flow_n | input | 1 | Static mode: 0 flow-through, 1 pipelined |
| order_il | input | 1 | Static burst order: 0 linear, 1 interleaved |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write command when 0, read when 1 |
| burst_next | input | 1 | Continue the current burst by one beat |
| lane_we_n | input | 2 | Per-lane write enables, active low |
| addr | input | 8 | Word address of a new command |
| wdata | input | 18 | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down, active high |
| rdata | output | 18 | Read data, 0 when not driven |
| rdata_vld | output | 1 | Read data is being driven |

## Verification
Two functions can fall on the same clock edge. One is the storing of a late write's data; the other is the read of that same address. In pipelined mode a read issued right after a write to the same address has its output register loaded at the very edge where that write's data arrives. The bench provokes this with write-then-read pairs, using full and partial lane masks. It compares each result against a reference array that is updated at the moment each command is issued, so any loss of the pending lanes, or of the stored lanes around them, shows up as a data mismatch.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flow_n,
  input  logic                      order_il,
  input  logic                      sel_a_n,
  input  logic                      sel_b,
  input  logic                      sel_c_n,
  input  logic                      we_n,
  input  logic                      burst_next,
  input  logic [LANES-1:0]          lane_we_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      oe_n,
  input  logic                      sleep,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rdata_vld
);

  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  // burst state
  logic              b_act, b_wr;
  logic [ADDR_W-1:0] b_addr;
  logic [1:0]        b_beat;

  // command pipeline
  logic              s1_v, s1_wr, s2_v, s2_wr, pv_q;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_be, s2_be;
  logic [DW-1:0]     dout;

  wire       sel      = !sel_a_n && sel_b && !sel_c_n;
  wire [1:0] nxt_beat = b_beat + 2'd1;
  wire [1:0] lsb_lin  = b_addr[1:0] + nxt_beat;
  wire [1:0] lsb_il   = b_addr[1:0] ^ nxt_beat;
  wire       cont     = burst_next && b_act && !sleep;
  wire       fresh    = !burst_next && sel && !sleep;

  wire              cmd_v  = cont || fresh;
  wire              cmd_wr = cont ? b_wr : !we_n;
  wire [ADDR_W-1:0] cmd_a  = cont ? {b_addr[ADDR_W-1:2], order_il ? lsb_il : lsb_lin} : addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act  <= 1'b0;
      b_wr   <= 1'b0;
      b_addr <= '0;
      b_beat <= '0;
      s1_v   <= 1'b0;
      s1_wr  <= 1'b0;
      s1_a   <= '0;
      s1_be  <= '0;
      s2_v   <= 1'b0;
      s2_wr  <= 1'b0;
      s2_a   <= '0;
      s2_be  <= '0;
      pv_q   <= 1'b0;
      dout   <= '0;
    end else begin
      if (sleep) begin
        b_act <= 1'b0;
      end else if (burst_next) begin
        if (b_act) b_beat <= nxt_beat;
      end else if (sel) begin
        b_act  <= 1'b1;
        b_wr   <= !we_n;
        b_addr <= addr;
        b_beat <= '0;
      end else begin
        b_act <= 1'b0;
      end
      s1_v  <= cmd_v;
      s1_wr <= cmd_wr;
      s1_a  <= cmd_a;
      s1_be <= ~lane_we_n;
      s2_v  <= s1_v;
      s2_wr <= s1_wr;
      s2_a  <= s1_a;
      s2_be <= s1_be;
      pv_q  <= s1_v && !s1_wr;
      dout  <= merged;
    end
  end

  // late write: one slot later in flow-through, two in pipelined
  wire              wr_fire = flow_n ? (s2_v && s2_wr) : (s1_v && s1_wr);
  wire [ADDR_W-1:0] wr_a    = flow_n ? s2_a : s1_a;
  wire [LANES-1:0]  wr_be   = flow_n ? s2_be : s1_be;

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (wr_fire && wr_be[l])
        mem[wr_a][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
  end

  wire [DW-1:0] mem_rd = mem[s1_a];
  wire          hit    = s2_v && s2_wr && (s2_a == s1_a);
  logic [DW-1:0] merged;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = (hit && s2_be[l]) ? wdata[l*LANE_W +: LANE_W]
                                                          : mem_rd[l*LANE_W +: LANE_W];
  end

  wire          vld_sync  = flow_n ? pv_q : (s1_v && !s1_wr);
  wire [DW-1:0] data_sync = flow_n ? dout : mem_rd;

  assign rdata_vld = vld_sync && !oe_n && !sleep;
  assign rdata     = rdata_vld ? data_sync : '0;

  a_r4_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_next && !sel) |=> !s1_v);

  a_r8_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!s1_v && !b_act));

  a_r7_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_next && b_act && !sleep) |=> (b_beat == $past(b_beat) + 2'd1));

  a_r6_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rdata_vld && rdata == '0));

  a_r2_pipe_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_n && !oe_n && !sleep && $past(s1_v && !s1_wr)) |-> rdata_vld);

endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
  localparam int AW = 8;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, flow_n, order_il, sel_a_n, sel_b, sel_c_n, we_n, burst_next, oe_n, sleep;
  logic [LN-1:0] lane_we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rdata_vld;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_zt_sram (
    .clk(clk), .rst_n(rst_n), .flow_n(flow_n), .order_il(order_il),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .we_n(we_n),
    .burst_next(burst_next), .lane_we_n(lane_we_n), .addr(addr), .wdata(wdata),
    .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rdata_vld(rdata_vld));

  // op: 0 read, 1 write, 2 burst continue; ces: 0 selected, 1 sel_a_n high, 2 sel_b low, 3 sel_c_n high
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  ces;
    logic [7:0]  a;
    logic [1:0]  ben;
    logic [17:0] d;
    logic [2:0]  tg;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 2'd0, 8'h10, 2'b00, 18'h2A5A5, 3'd0},
    '{2'd0, 2'd0, 8'h10, 2'b11, 18'h00000, 3'd3},
    '{2'd1, 2'd0, 8'h11, 2'b10, 18'h3FFFF, 3'd0},
    '{2'd0, 2'd0, 8'h11, 2'b11, 18'h00000, 3'd3},
    '{2'd1, 2'd0, 8'h10, 2'b01, 18'h00000, 3'd0},
    '{2'd0, 2'd0, 8'h11, 2'b11, 18'h00000, 3'd1},
    '{2'd0, 2'd0, 8'h10, 2'b11, 18'h00000, 3'd1},
    '{2'd1, 2'd0, 8'h21, 2'b00, 18'h12345, 3'd2},
    '{2'd2, 2'd0, 8'h00, 2'b00, 18'h23456, 3'd2},
    '{2'd2, 2'd0, 8'h00, 2'b00, 18'h34567, 3'd2},
    '{2'd2, 2'd0, 8'h00, 2'b00, 18'h05678, 3'd2},
    '{2'd0, 2'd0, 8'h23, 2'b11, 18'h00000, 3'd2},
    '{2'd2, 2'd0, 8'h00, 2'b11, 18'h00000, 3'd2},
    '{2'd2, 2'd0, 8'h00, 2'b11, 18'h00000, 3'd2},
    '{2'd2, 2'd0, 8'h00, 2'b11, 18'h00000, 3'd2},
    '{2'd2, 2'd0, 8'h00, 2'b11, 18'h00000, 3'd2},
    '{2'd1, 2'd2, 8'h40, 2'b00, 18'h11111, 3'd4},
    '{2'd2, 2'd0, 8'h00, 2'b00, 18'h01010, 3'd4},
    '{2'd0, 2'd0, 8'h40, 2'b11, 18'h00000, 3'd4},
    '{2'd1, 2'd1, 8'h41, 2'b00, 18'h22222, 3'd4},
    '{2'd1, 2'd3, 8'h41, 2'b00, 18'h33333, 3'd4},
    '{2'd0, 2'd0, 8'h41, 2'b11, 18'h00000, 3'd4},
    '{2'd1, 2'd0, 8'h13, 2'b00, 18'h0F0F0, 3'd0},
    '{2'd0, 2'd0, 8'h12, 2'b11, 18'h00000, 3'd0},
    '{2'd0, 2'd0, 8'h13, 2'b11, 18'h00000, 3'd0}
  };

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int probe = 0;

  logic [DW-1:0] ref_mem [256];
  logic          exp_v [8];
  logic [DW-1:0] exp_d [8];
  string         exp_t [8];
  logic [DW-1:0] wq    [8];
  logic          m_act, m_wr;
  logic [7:0]    m_base;
  logic [1:0]    m_beat;

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tname(input int tg, input logic fl);
    case (tg)
      0:       return fl ? "R1 R2 pipelined" : "R1 R3 flow-through";
      1:       return "R5 byte lanes";
      2:       return "R7 burst order";
      3:       return "R9 pending merge";
      default: return "R4 R10 deselect";
    endcase
  endfunction

  // one bus cycle: check the slot ending at the coming edge, then drive the command for it
  task automatic step(input int op, input int ces, input logic [7:0] a, input logic [1:0] ben,
                      input logic [17:0] d, input string tag, input bit slp);
    int k, s, lat;
    bit v, w;
    logic [7:0] ea;
    logic old_sleep;
    @(negedge clk);
    k = cyc % 8;
    old_sleep = sleep;
    if (probe == 1) begin
      oe_n = 1'b1; #1;
      chk("R6 oe off", rdata_vld === 1'b0 && rdata === '0, {13'b0, rdata_vld, rdata}, 32'h0);
      oe_n = 1'b0; #1;
    end else if (probe == 2) begin
      sleep = 1'b1; #1;
      chk("R8 sleep off", rdata_vld === 1'b0 && rdata === '0, {13'b0, rdata_vld, rdata}, 32'h0);
      sleep = old_sleep; #1;
    end
    probe = 0;
    if (exp_v[k] && !sleep)
      chk(exp_t[k], rdata_vld === 1'b1 && rdata === exp_d[k],
          {13'b0, rdata_vld, rdata}, {13'b0, 1'b1, exp_d[k]});
    else
      chk(sleep ? "R8 asleep" : exp_t[k], rdata_vld === 1'b0 && rdata === '0,
          {13'b0, rdata_vld, rdata}, 32'h0);
    exp_v[k] = 1'b0;
    exp_t[k] = "R10 idle";
    wdata = wq[k];
    wq[k] = '0;
    sel_a_n    = (ces == 1);
    sel_b      = (ces != 2);
    sel_c_n    = (ces == 3);
    we_n       = !(op == 1);
    burst_next = (op == 2);
    addr       = a;
    lane_we_n  = ben;
    sleep      = slp;
    lat = flow_n ? 2 : 1;
    s = (cyc + lat) % 8;
    exp_t[s] = tag;
    v = 1'b0;
    w = 1'b0;
    ea = '0;
    if (slp) begin
      m_act = 1'b0;
    end else if (op == 2) begin
      if (m_act) begin
        m_beat = m_beat + 2'd1;
        ea = {m_base[7:2], order_il ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat)};
        w = m_wr;
        v = 1'b1;
      end
    end else if (ces == 0) begin
      m_act = 1'b1; m_wr = (op == 1); m_base = a; m_beat = 2'd0;
      ea = a; w = m_wr; v = 1'b1;
    end else begin
      m_act = 1'b0;
    end
    if (v && w) begin
      for (int l = 0; l < LN; l++)
        if (!ben[l]) ref_mem[ea][l*LW +: LW] = d[l*LW +: LW];
      wq[s] = d;
    end else if (v) begin
      exp_v[s] = 1'b1;
      exp_d[s] = ref_mem[ea];
    end
    cyc++;
  endtask

  task automatic drain();
    repeat (3) step(0, 2, 8'h00, 2'b11, 18'h0, "R10 drain", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flow_n = 1'b1; order_il = 1'b0;
    sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1; we_n = 1'b1; burst_next = 1'b0;
    lane_we_n = 2'b11; addr = '0; wdata = '0; oe_n = 1'b0; sleep = 1'b0;
    m_act = 1'b0; m_wr = 1'b0; m_base = '0; m_beat = '0;
    for (int i = 0; i < 8; i++) begin
      exp_v[i] = 1'b0; exp_d[i] = '0; exp_t[i] = "R11 reset"; wq[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R11: quiet during reset
    chk("R11 in reset", rdata_vld === 1'b0 && rdata === '0, {13'b0, rdata_vld, rdata}, 32'h0);
    rst_n = 1'b1;

    // fill every word so that all reads return known data
    for (int a = 0; a < 256; a++)
      step(1, 0, a[7:0], 2'b00, {2'b10, a[7:0], a[7:0] ^ 8'hC3}, "R11 after reset", 1'b0);
    drain();

    // table walk: both latency modes, both burst orders
    for (int m = 0; m < 4; m++) begin
      flow_n   = (m < 2);
      order_il = (m % 2 == 1);
      for (int i = 0; i < NV; i++)
        step(int'(TBL[i].op), int'(TBL[i].ces), TBL[i].a, TBL[i].ben, TBL[i].d,
             tname(int'(TBL[i].tg), flow_n), 1'b0);
      drain();
    end

    // R6: output enable off mid-slot, flow-through then pipelined
    flow_n = 1'b0;
    step(0, 0, 8'h10, 2'b11, 18'h0, "R3 read before oe probe", 1'b0);
    probe = 1;
    step(0, 2, 8'h00, 2'b11, 18'h0, "R6 oe restored", 1'b0);
    drain();
    flow_n = 1'b1;
    step(0, 0, 8'h11, 2'b11, 18'h0, "R2 read before oe probe", 1'b0);
    step(0, 2, 8'h00, 2'b11, 18'h0, "R10 gap", 1'b0);
    probe = 1;
    step(0, 2, 8'h00, 2'b11, 18'h0, "R6 oe restored", 1'b0);
    drain();

    // R8: command under sleep ignored, burst ended, outputs forced off
    step(1, 0, 8'h30, 2'b00, 18'h15555, "R8 sleep write slot", 1'b1);
    step(2, 0, 8'h00, 2'b00, 18'h2AAAA, "R8 burst after sleep", 1'b0);
    step(0, 0, 8'h30, 2'b11, 18'h0, "R8 word kept after sleep", 1'b0);
    step(0, 2, 8'h00, 2'b11, 18'h0, "R10 gap", 1'b0);
    probe = 2;
    step(0, 2, 8'h00, 2'b11, 18'h0, "R8 sleep restored", 1'b0);
    drain();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule